// File: doc/BRIEF.md
# Supply Monitor Reset Filter

This block is the digital control for a supply-voltage monitor. Two comparator results reach it already synchronised to the clock. One says the supply is at or below the falling trip level. The other says the supply is above the higher rising trip level.

The block raises a reset request only after the low indication has lasted through a run of consecutive cycles. It holds that reset until the rising indication appears, then drops it. An active-low pin drive mirrors the reset so that devices outside the chip are held as well. An unfiltered status flag shows the live comparator state.

Three configuration inputs control the block. The first turns monitoring on. The second allows a reset to be generated. The third keeps the monitor running while the chip is in stop mode. The analog reference and the comparator are not part of this block.

Top module: `supply_guard`

## Requirements
- R1: While `cfgMonEn` is 0, the comparator inputs are ignored. `lowFlag` reads 0 one cycle later, no new reset is raised, and the consecutive-low count restarts from zero once monitoring resumes.
- R2: While `cfgRstEn` is 0, no new reset is raised. `lowFlag` keeps tracking `belowFall` in that state.
- R3: `rstReq` goes to 1 on the clock edge that samples `belowFall` = 1 for the FILTER_LEN-th consecutive active cycle (default 9), with reset generation enabled. After only FILTER_LEN-1 such cycles it stays 0. A single sampled cycle with `belowFall` = 0 restarts the count.
- R4: Once `rstReq` is 1, it stays 1 until an edge samples `aboveRise` = 1. That single edge clears it.
- R5: `rstPinN` is always the inverse of `rstReq`, in the same cycle. It is driven low while a reset is held.
- R6: While monitoring is active, `lowFlag` equals the value of `belowFall` sampled at the previous edge, with no filtering.
- R7: With `stopMode` = 1 and `cfgStopEn` = 0, monitoring is suspended. `lowFlag` reads 0, no reset is raised and the count is cleared. With `cfgStopEn` = 1, monitoring continues unchanged during stop.
- R8: A reset that is already held stays held when monitoring is disabled or suspended. It is released only through the R4 rule.
- R9: While `rstN` is low and after it rises, the outputs read `rstReq` = 0, `rstPinN` = 1 and `lowFlag` = 0. Monitoring starts at once with the configured enables.
- R10: The consecutive-low count saturates at FILTER_LEN rather than wrapping. A long low run therefore trips on the first edge after `cfgRstEn` is set. The count is cleared when a reset is released, so a new trip needs a fresh full run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| cfgMonEn | input | 1 | Monitoring enable |
| cfgRstEn | input | 1 | Reset generation enable |
| cfgStopEn | input | 1 | Keep monitoring during stop mode |
| stopMode | input | 1 | Chip is in stop mode |
| belowFall | input | 1 | Supply at or below falling trip level (synchronised) |
| aboveRise | input | 1 | Supply above rising trip level (synchronised) |
| rstReq | output | 1 | Internal reset request, registered |
| rstPinN | output | 1 | Active-low external reset pin drive, registered |
| lowFlag | output | 1 | Unfiltered low-supply status, registered |

## Verification
The assertions check the following on every cycle:
- the pin is the inverse of the request;
- a held reset survives until a rising indication and falls on the edge after one;
- no new reset appears while monitoring, reset generation or stop-mode operation rules it out, or while the supply is not low;
- the status flag follows the comparator one cycle late;
- no reset rises before a checker-side run counter has seen a full run of low cycles.

Only the bench scenarios can show three further things. The first is the exact cycle of the trip, ninth edge against eighth. The second is that the count restarts after a gap, a release or a disable. The third is that a saturated count trips immediately once reset generation is switched on.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  // Strobes from the control module to the run-length datapath.
  typedef struct packed {
    logic incCnt;    // another low cycle observed while active
    logic clearCnt;  // restart the run from zero
  } guardStrobes_t;

endpackage

// File: rtl/supply_guard_filter.sv
module supply_guard_filter
  import supply_guard_pkg::*;
#(
  parameter int FILTER_LEN = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  output logic          atLimit
);

  localparam int CNT_W = $clog2(FILTER_LEN + 1);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(FILTER_LEN);
  localparam logic [CNT_W-1:0] PRE_VAL = CNT_W'(FILTER_LEN - 1);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runCntNext;

  always_comb begin
    runCntNext = runCnt;
    if (strobes.clearCnt) begin
      runCntNext = '0;
    end else if (strobes.incCnt && (runCnt != SAT_VAL)) begin
      runCntNext = runCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else begin
      runCnt <= runCntNext;
    end
  end

  // True when one more low cycle completes (or has completed) the run.
  assign atLimit = (runCnt >= PRE_VAL);

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgMonEn,
  input  logic          cfgRstEn,
  input  logic          cfgStopEn,
  input  logic          stopMode,
  input  logic          belowFall,
  input  logic          aboveRise,
  input  logic          atLimit,
  output guardStrobes_t strobes,
  output logic          rstReq,
  output logic          rstPinN,
  output logic          lowFlag
);

  logic monActive;
  logic holdNow;
  logic holdNext;
  logic releaseHold;
  logic setHold;

  assign holdNow     = rstReq;
  assign monActive   = cfgMonEn && (!stopMode || cfgStopEn);
  assign releaseHold = holdNow && aboveRise;
  assign setHold     = !holdNow && monActive && cfgRstEn && belowFall && atLimit;

  always_comb begin
    strobes.incCnt   = monActive && belowFall && !releaseHold;
    strobes.clearCnt = !strobes.incCnt;
  end

  always_comb begin
    holdNext = holdNow;
    if (releaseHold) begin
      holdNext = 1'b0;
    end else if (setHold) begin
      holdNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq  <= 1'b0;
      rstPinN <= 1'b1;
      lowFlag <= 1'b0;
    end else begin
      rstReq  <= holdNext;
      rstPinN <= !holdNext;
      lowFlag <= monActive && belowFall;
    end
  end

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int FILTER_LEN = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgMonEn,
  input  logic cfgRstEn,
  input  logic cfgStopEn,
  input  logic stopMode,
  input  logic belowFall,
  input  logic aboveRise,
  output logic rstReq,
  output logic rstPinN,
  output logic lowFlag
);

  guardStrobes_t strobes;
  logic          atLimit;

  supply_guard_filter #(.FILTER_LEN(FILTER_LEN)) uFilter (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .atLimit (atLimit)
  );

  supply_guard_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgMonEn  (cfgMonEn),
    .cfgRstEn  (cfgRstEn),
    .cfgStopEn (cfgStopEn),
    .stopMode  (stopMode),
    .belowFall (belowFall),
    .aboveRise (aboveRise),
    .atLimit   (atLimit),
    .strobes   (strobes),
    .rstReq    (rstReq),
    .rstPinN   (rstPinN),
    .lowFlag   (lowFlag)
  );

endmodule

// File: rtl/supply_guard_checker.sv
module supply_guard_checker #(
  parameter int FILTER_LEN = 9
) (
  input logic clk,
  input logic rstN,
  input logic cfgMonEn,
  input logic cfgRstEn,
  input logic cfgStopEn,
  input logic stopMode,
  input logic belowFall,
  input logic aboveRise,
  input logic rstReq,
  input logic rstPinN,
  input logic lowFlag
);

  localparam int RUN_W = $clog2(FILTER_LEN + 1);

  logic             chkActive;
  logic [RUN_W-1:0] runLen;

  assign chkActive = cfgMonEn && (!stopMode || cfgStopEn);

  // Independent run counter of active low cycles, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (chkActive && belowFall) begin
      if (runLen != RUN_W'(FILTER_LEN)) runLen <= runLen + RUN_W'(1);
    end else begin
      runLen <= '0;
    end
  end

  assert_disabled_no_trip_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMonEn && !rstReq) |=> !rstReq);

  assert_disabled_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMonEn |=> !lowFlag);

  assert_gate_no_trip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRstEn && !rstReq) |=> !rstReq);

  assert_filter_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> (runLen >= RUN_W'(FILTER_LEN)));

  assert_high_no_trip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!belowFall && !rstReq) |=> !rstReq);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && aboveRise) |=> !rstReq);

  assert_pin_inverse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstPinN != rstReq);

  assert_flag_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chkActive && belowFall) |=> lowFlag);

  assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !belowFall |=> !lowFlag);

  assert_stop_suspend_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !cfgStopEn && !rstReq) |=> (!rstReq && !lowFlag));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && !aboveRise) |=> rstReq);

endmodule

bind supply_guard supply_guard_checker #(.FILTER_LEN(FILTER_LEN)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .cfgMonEn  (cfgMonEn),
  .cfgRstEn  (cfgRstEn),
  .cfgStopEn (cfgStopEn),
  .stopMode  (stopMode),
  .belowFall (belowFall),
  .aboveRise (aboveRise),
  .rstReq    (rstReq),
  .rstPinN   (rstPinN),
  .lowFlag   (lowFlag)
);

// File: tb/supply_guard_test.sv
module supply_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEN = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMonEn = 1'b1;
  logic cfgRstEn = 1'b1;
  logic cfgStopEn = 1'b0;
  logic stopMode = 1'b0;
  logic belowFall = 1'b0;
  logic aboveRise = 1'b0;
  logic rstReq;
  logic rstPinN;
  logic lowFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [2:0] expQ[$];
  string      tagQ[$];
  event       chkEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_guard #(.FILTER_LEN(LEN)) uut (
    .clk(clk), .rstN(rstN), .cfgMonEn(cfgMonEn), .cfgRstEn(cfgRstEn),
    .cfgStopEn(cfgStopEn), .stopMode(stopMode), .belowFall(belowFall),
    .aboveRise(aboveRise), .rstReq(rstReq), .rstPinN(rstPinN), .lowFlag(lowFlag)
  );

  // Driver side: push the expected {rstReq, rstPinN, lowFlag}.
  task automatic expectOut(input logic req, input logic pin, input logic flag, input string tag);
    expQ.push_back({req, pin, flag});
    tagQ.push_back(tag);
    -> chkEv;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drives a full low run and checks the trip, then releases it.
  task automatic tripAndRelease(input string tag);
    belowFall = 1'b1;
    step(LEN);
    expectOut(1'b1, 1'b0, 1'b1, tag);
    belowFall = 1'b0;
    aboveRise = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b0, tag);
    aboveRise = 1'b0;
  endtask

  // Monitor side: pop and compare against the live outputs.
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        logic [2:0] e;
        logic [2:0] a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = {rstReq, rstPinN, lowFlag};
        compared++;
        if (a !== e) begin
          mismatched++;
          $display("FAIL %s: {rstReq,rstPinN,lowFlag} actual=%b expected=%b at %0t", t, a, e, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R9: reset state, both during and right after reset
    step(3);
    expectOut(1'b0, 1'b1, 1'b0, "R9 in reset");
    rstN = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b0, "R9 after reset");

    // R6, R3, R5, R4: basic trip, hold and release
    belowFall = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b1, "R6 flag follows at once");
    step(LEN - 2);
    expectOut(1'b0, 1'b1, 1'b1, "R3 eight lows no trip");
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R3 R5 ninth low trips, pin low");
    belowFall = 1'b0;
    step(3);
    expectOut(1'b1, 1'b0, 1'b0, "R4 held without rising, R6 flag clears");
    aboveRise = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b0, "R4 one rising cycle releases");
    aboveRise = 1'b0;

    // R3: a single high cycle restarts the run
    belowFall = 1'b1;
    step(5);
    belowFall = 1'b0;
    step(1);
    belowFall = 1'b1;
    step(LEN - 1);
    expectOut(1'b0, 1'b1, 1'b1, "R3 gap restarts count");
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R3 trip after fresh run");
    aboveRise = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b1, "R4 release while still low");
    aboveRise = 1'b0;

    // R10: release cleared the count; the low run continues from zero
    step(LEN - 1);
    expectOut(1'b0, 1'b1, 1'b1, "R10 count cleared on release");
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R10 retrip after full run");
    belowFall = 1'b0;
    aboveRise = 1'b1;
    step(1);
    aboveRise = 1'b0;
    expectOut(1'b0, 1'b1, 1'b0, "R4 release");

    // R2 and R10: reset gated off, then saturated count trips at once
    cfgRstEn = 1'b0;
    belowFall = 1'b1;
    step(20);
    expectOut(1'b0, 1'b1, 1'b1, "R2 no reset, flag tracks");
    cfgRstEn = 1'b1;
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R10 saturated count trips at once");
    belowFall = 1'b0;
    aboveRise = 1'b1;
    step(1);
    aboveRise = 1'b0;
    expectOut(1'b0, 1'b1, 1'b0, "R4 release");

    // R1: monitoring off ignores inputs and leaves count at zero
    cfgMonEn = 1'b0;
    belowFall = 1'b1;
    step(15);
    expectOut(1'b0, 1'b1, 1'b0, "R1 disabled ignores low");
    cfgMonEn = 1'b1;
    step(LEN - 1);
    expectOut(1'b0, 1'b1, 1'b1, "R1 count restarts on enable");
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R1 full run after enable trips");
    belowFall = 1'b0;
    aboveRise = 1'b1;
    step(1);
    aboveRise = 1'b0;
    expectOut(1'b0, 1'b1, 1'b0, "R4 release");

    // R7: stop mode suspends unless stop-enable is set
    stopMode = 1'b1;
    belowFall = 1'b1;
    step(12);
    expectOut(1'b0, 1'b1, 1'b0, "R7 suspended in stop");
    cfgStopEn = 1'b1;
    step(LEN - 1);
    expectOut(1'b0, 1'b1, 1'b1, "R7 stop-enabled count from zero");
    step(1);
    expectOut(1'b1, 1'b0, 1'b1, "R7 trip during stop");
    belowFall = 1'b0;
    aboveRise = 1'b1;
    step(1);
    aboveRise = 1'b0;
    expectOut(1'b0, 1'b1, 1'b0, "R4 release in stop");
    stopMode = 1'b0;
    cfgStopEn = 1'b0;

    // R8: held reset survives disable and suspension
    tripAndRelease("R5 trip before hold test");
    belowFall = 1'b1;
    step(LEN);
    expectOut(1'b1, 1'b0, 1'b1, "R8 tripped");
    cfgMonEn = 1'b0;
    belowFall = 1'b0;
    step(5);
    expectOut(1'b1, 1'b0, 1'b0, "R8 held while disabled");
    cfgMonEn = 1'b1;
    stopMode = 1'b1;
    step(4);
    expectOut(1'b1, 1'b0, 1'b0, "R8 held while suspended");
    aboveRise = 1'b1;
    step(1);
    expectOut(1'b0, 1'b1, 1'b0, "R8 released only by rising");
    aboveRise = 1'b0;
    stopMode = 1'b0;

    step(2);
    finished = 1'b1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule